// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a signal-processing datapath. On every enabled clock cycle it multiplies two signed two's-complement operands of `DATA_W` bits into a product of twice that width, with no bits lost. The product is then either added to a running sum or loaded in place of it, which starts a new sum. The running sum is held in an accumulator that is wider than the product by `GUARD_W` extra high bits, so long sums can run past the product range without harm.

A combinational store path turns the wide accumulator into one `DATA_W`-bit word for memory. Operands and the result word are treated as signed fractions. The path therefore drops the low `DATA_W-1` bits of the accumulator. It rounds the result by one of three selectable rules: truncate, round half upward, or round half to even. It then clamps the result to the signed `DATA_W`-bit range instead of letting it wrap.

A two-state flag machine records clamping. It starts in state QUIET. The transition QUIET to LATCHED is taken on any clock edge where the store path is clamping. The transition LATCHED to QUIET is taken only on an edge where the clear input is high and no clamping is present. Otherwise the machine keeps its state.

Top module: `sat_mac_unit`

## Requirements
- R1: When `mac_en` and `mac_load` are both high, then after the clock edge `acc_val` equals the exact signed product `op_a*op_b`, sign-extended to `ACC_W = 2*DATA_W+GUARD_W` bits.
- R2: When `mac_en` is high and `mac_load` is low, the signed product is added to `acc_val` at the clock edge. The sum wraps modulo 2^ACC_W.
- R3: The load in R1 discards the previous accumulator contents completely.
- R4: When `mac_en` is low, `acc_val` keeps its value, whatever `mac_load`, `op_a` and `op_b` are.
- R5: `rnd_sel` = 00 (and the spare code 11) gives truncation. The result before clamping is floor(acc / 2^(DATA_W-1)).
- R6: `rnd_sel` = 01 gives round-to-nearest. A discarded fraction of one half or more rounds up, toward more positive. A smaller fraction rounds down.
- R7: `rnd_sel` = 10 gives convergent rounding. A discarded fraction above one half rounds up and one below one half rounds down. An exact half adds one only when the kept LSB is 1, so the result LSB becomes 0.
- R8: A rounded value above 2^(DATA_W-1)-1 gives exactly that value on `word_out`. A rounded value below -2^(DATA_W-1) gives exactly that value. `sat_now` is high exactly when one of these clamps applies.
- R9: `sat_sticky` rises on the edge after any edge where `sat_now` is high. It returns low only on an edge where `flag_clr` is high and `sat_now` is low. When both are high on the same edge, the flag stays set.
- R10: While `rst_n` is low, the accumulator is zero and the flag is QUIET. Out of reset, `acc_val`, `word_out`, `sat_now` and `sat_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mac_en | input | 1 | Perform an operation this cycle |
| mac_load | input | 1 | Load the product instead of adding it |
| op_a | input | DATA_W | Signed operand A |
| op_b | input | DATA_W | Signed operand B |
| rnd_sel | input | 2 | Rounding rule for the store path |
| flag_clr | input | 1 | Request to clear the sticky flag |
| acc_val | output | 2*DATA_W+GUARD_W | Accumulator contents |
| word_out | output | DATA_W | Rounded, clamped store word |
| sat_now | output | 1 | Store word is clamped this cycle |
| sat_sticky | output | 1 | Clamping has occurred since the last clear |

## Verification
The hardest cases to reach from the ports are exact-half ties, which convergent rounding resolves differently for odd and even kept values. The bench reaches them by sweeping every operand pair in a 4-bit configuration. That sweep puts every residue of the three dropped bits into the accumulator, with both parities of the kept LSB, and checks all four mode codes against an integer model. The collision between clamping and a clear request is also hard to reach. The bench creates it by loading a product that clamps and pulsing the clear input on the very next edge. A long run of large products then drives the sum through the guard bits until it wraps.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        RND_TRUNC = 2'b00,
        RND_NEAR  = 2'b01,
        RND_CONV  = 2'b10,
        RND_SPARE = 2'b11
    } rnd_mode_e;

    typedef enum logic {
        FLG_QUIET   = 1'b0,
        FLG_LATCHED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]   mul_a,
    input  logic [DATA_W-1:0]   mul_b,
    output logic [2*DATA_W-1:0] mul_p
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;

    // Sign-extend both operands to full product width so no bit is lost.
    assign a_ext = PROD_W'($signed(mul_a));
    assign b_ext = PROD_W'($signed(mul_b));
    assign mul_p = a_ext * b_ext;

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int PROD_W  = 32,
    parameter int GUARD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      load,
    input  logic [PROD_W-1:0]         prod,
    output logic [PROD_W+GUARD_W-1:0] acc
);
    localparam int ACC_W = PROD_W + GUARD_W;

    logic [ACC_W-1:0] prod_ext;

    assign prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            if (load) begin
                acc <= prod_ext;
            end else begin
                acc <= acc + prod_ext;
            end
        end
    end

endmodule

// File: rtl/mac_store.sv
module mac_store
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] word,
    output logic              sat
);
    localparam int SHIFT  = DATA_W - 1;
    localparam int KEEP_W = ACC_W - SHIFT;
    localparam int RND_W  = KEEP_W + 1;
    localparam logic [SHIFT-1:0] HALF_V = SHIFT'(64'd1 << (SHIFT - 1));
    localparam logic signed [RND_W-1:0] MAX_V = RND_W'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [RND_W-1:0] MIN_V = ~MAX_V;

    logic [KEEP_W-1:0]       kept;
    logic [SHIFT-1:0]        low;
    logic                    inc;
    logic signed [RND_W-1:0] rounded;
    logic                    over;
    logic                    under;

    assign kept = acc[ACC_W-1:SHIFT];
    assign low  = acc[SHIFT-1:0];

    always_comb begin
        inc = 1'b0;
        unique case (rnd_mode_e'(mode))
            RND_TRUNC: inc = 1'b0;
            RND_NEAR:  inc = low[SHIFT-1];
            RND_CONV:  inc = (low > HALF_V) || ((low == HALF_V) && kept[0]);
            RND_SPARE: inc = 1'b0;
            default:   inc = 1'b0;
        endcase
    end

    assign rounded = $signed({kept[KEEP_W-1], kept}) + $signed({{(RND_W-1){1'b0}}, inc});
    assign over    = rounded > MAX_V;
    assign under   = rounded < MIN_V;
    assign sat     = over || under;

    always_comb begin
        if (over) begin
            word = MAX_V[DATA_W-1:0];
        end else if (under) begin
            word = MIN_V[DATA_W-1:0];
        end else begin
            word = rounded[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/mac_ovf_fsm.sv
module mac_ovf_fsm
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sat_in,
    input  logic clr,
    output logic sticky
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_QUIET: begin
                if (sat_in) state_d = FLG_LATCHED;
            end
            FLG_LATCHED: begin
                if (clr && !sat_in) state_d = FLG_QUIET;
            end
            default: state_d = FLG_QUIET;
        endcase
    end

    always_comb begin
        sticky = (state_q == FLG_LATCHED);
    end

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mac_en,
    input  logic                          mac_load,
    input  logic [DATA_W-1:0]             op_a,
    input  logic [DATA_W-1:0]             op_b,
    input  logic [1:0]                    rnd_sel,
    input  logic                          flag_clr,
    output logic [2*DATA_W+GUARD_W-1:0]   acc_val,
    output logic [DATA_W-1:0]             word_out,
    output logic                          sat_now,
    output logic                          sat_sticky
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = PROD_W + GUARD_W;

    logic [PROD_W-1:0] prod;

    mac_mult #(.DATA_W(DATA_W)) u_mult (
        .mul_a (op_a),
        .mul_b (op_b),
        .mul_p (prod)
    );

    mac_accum #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mac_en),
        .load  (mac_load),
        .prod  (prod),
        .acc   (acc_val)
    );

    mac_store #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_store (
        .acc  (acc_val),
        .mode (rnd_sel),
        .word (word_out),
        .sat  (sat_now)
    );

    mac_ovf_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .sat_in (sat_now),
        .clr    (flag_clr),
        .sticky (sat_sticky)
    );

endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        mac_en,
    input logic                        mac_load,
    input logic [DATA_W-1:0]           op_a,
    input logic [DATA_W-1:0]           op_b,
    input logic                        flag_clr,
    input logic [2*DATA_W+GUARD_W-1:0] acc_val,
    input logic [DATA_W-1:0]           word_out,
    input logic                        sat_now,
    input logic                        sat_sticky
);
    localparam int ACC_W = 2 * DATA_W + GUARD_W;
    localparam logic [DATA_W-1:0] TOP_V = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] BOT_V = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] a_x;
    logic signed [ACC_W-1:0] b_x;
    logic [ACC_W-1:0]        p_x;

    assign a_x = ACC_W'($signed(op_a));
    assign b_x = ACC_W'($signed(op_b));
    assign p_x = a_x * b_x;

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mac_en && mac_load |=> acc_val == $past(p_x));

    p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mac_en && !mac_load |=> acc_val == $past(acc_val + p_x));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_en |=> $stable(acc_val));

    p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sat_now |-> (word_out == TOP_V || word_out == BOT_V));

    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_now |=> sat_sticky);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !sat_now |=> !sat_sticky);

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky && !flag_clr |=> sat_sticky);

endmodule

bind sat_mac_unit mac_checker #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_en     (mac_en),
    .mac_load   (mac_load),
    .op_a       (op_a),
    .op_b       (op_b),
    .flag_clr   (flag_clr),
    .acc_val    (acc_val),
    .word_out   (word_out),
    .sat_now    (sat_now),
    .sat_sticky (sat_sticky)
);

// File: tb/test_sat_mac_unit.sv
`timescale 1ns/100ps
module test_sat_mac_unit;
    localparam int DW  = 4;
    localparam int GW  = 3;
    localparam int AW  = 2 * DW + GW;
    localparam int SH  = DW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mac_en = 1'b0;
    logic          mac_load = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic [1:0]    rnd_sel = 2'b00;
    logic          flag_clr = 1'b0;
    logic [AW-1:0] acc_val;
    logic [DW-1:0] word_out;
    logic          sat_now;
    logic          sat_sticky;

    int checks = 0;
    int errors = 0;
    int m_acc  = 0;

    always #2 clk = ~clk;

    sat_mac_unit #(.DATA_W(DW), .GUARD_W(GW)) i_sat_mac_unit (
        .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .mac_load(mac_load),
        .op_a(op_a), .op_b(op_b), .rnd_sel(rnd_sel), .flag_clr(flag_clr),
        .acc_val(acc_val), .word_out(word_out), .sat_now(sat_now),
        .sat_sticky(sat_sticky)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wrap(input int v);
        int w;
        w = v & ((1 << AW) - 1);
        if (w >= (1 << (AW - 1))) w = w - (1 << AW);
        return w;
    endfunction

    function automatic int model_word(input int acc, input int mode, output bit s);
        int kept;
        int low;
        int half;
        int r;
        int mx;
        kept = acc >>> SH;
        low  = acc - (kept <<< SH);
        half = 1 << (SH - 1);
        r    = kept;
        if (mode == 1 && low >= half) r = kept + 1;
        if (mode == 2 && (low > half || (low == half && (kept & 1) == 1))) r = kept + 1;
        mx = (1 << (DW - 1)) - 1;
        s  = 1'b0;
        if (r > mx) begin r = mx; s = 1'b1; end
        if (r < -mx - 1) begin r = -mx - 1; s = 1'b1; end
        return r;
    endfunction

    task automatic step(input bit en, input bit ld, input int a, input int b, input bit clr);
        @(negedge clk);
        mac_en   = en;
        mac_load = ld;
        op_a     = DW'(a);
        op_b     = DW'(b);
        flag_clr = clr;
        rnd_sel  = 2'b00;
        @(posedge clk);
        #1;
    endtask

    task automatic check_store();
        bit s;
        int e;
        string tag;
        for (int m = 0; m < 4; m++) begin
            rnd_sel = 2'(m);
            #0.2;
            e = model_word(m_acc, m, s);
            tag = (m == 1) ? "R6" : (m == 2) ? "R7" : "R5";
            chk(int'($signed(word_out)) == e, tag, int'($signed(word_out)), e);
            chk(sat_now == s, "R8", int'(sat_now), int'(s));
        end
        rnd_sel = 2'b00;
    endtask

    task automatic check_acc(input string req);
        chk(int'($signed(acc_val)) == m_acc, req, int'($signed(acc_val)), m_acc);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset values
        chk(acc_val == '0, "R10", int'(acc_val), 0);
        chk(sat_sticky == 1'b0, "R10", int'(sat_sticky), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk(word_out == '0 && sat_now == 1'b0, "R10", int'(word_out), 0);

        // R1 R3 with R5..R8: exhaustive operand sweep, each loaded fresh
        for (int a = -(1 << (DW - 1)); a < (1 << (DW - 1)); a++) begin
            for (int b = -(1 << (DW - 1)); b < (1 << (DW - 1)); b++) begin
                step(1'b1, 1'b1, a, b, 1'b0);
                m_acc = a * b;
                check_acc("R1 R3");
                check_store();
            end
        end

        // R2: large products accumulated through the guard bits until wrap
        step(1'b1, 1'b1, -8, -8, 1'b0);
        m_acc = 64;
        check_acc("R3");
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, -8, -8, 1'b0);
            m_acc = wrap(m_acc + 64);
            check_acc("R2");
            check_store();
        end

        // R2: mixed-sign accumulation
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, i - 8, ((3 * i) % 16) - 8, 1'b0);
            m_acc = wrap(m_acc + (i - 8) * (((3 * i) % 16) - 8));
            check_acc("R2");
            check_store();
        end

        // R4: disabled cycles keep the sum, even with load requested
        step(1'b0, 1'b0, 5, 5, 1'b0);
        check_acc("R4");
        step(1'b0, 1'b1, -7, 3, 1'b0);
        check_acc("R4");

        // R9: sticky flag sequence
        step(1'b1, 1'b1, 0, 0, 1'b0);
        m_acc = 0;
        step(1'b0, 1'b0, 0, 0, 1'b1);
        chk(sat_sticky == 1'b0, "R9", int'(sat_sticky), 0);
        step(1'b1, 1'b1, -8, -8, 1'b0);
        m_acc = 64;
        chk(sat_now == 1'b1, "R8", int'(sat_now), 1);
        chk(sat_sticky == 1'b0, "R9", int'(sat_sticky), 0);
        step(1'b0, 1'b0, 0, 0, 1'b1);
        chk(sat_sticky == 1'b1, "R9", int'(sat_sticky), 1);
        step(1'b1, 1'b1, 1, 1, 1'b0);
        m_acc = 1;
        chk(sat_sticky == 1'b1, "R9", int'(sat_sticky), 1);
        step(1'b0, 1'b0, 0, 0, 1'b0);
        chk(sat_sticky == 1'b1, "R9", int'(sat_sticky), 1);
        step(1'b0, 1'b0, 0, 0, 1'b1);
        chk(sat_sticky == 1'b0, "R9", int'(sat_sticky), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule